// File: doc/BRIEF.md
# Packed Pixel Format Converter

This block converts one pixel per transfer between a 32-bit word of four 8-bit channels and a 16-bit word made of one single-bit channel and three 5-bit colour channels. A direction input chooses the conversion for each transfer. Packing keeps the five most significant bits of each colour byte and one bit of the top byte. Unpacking widens each 5-bit field back to a full byte by repeating its high bits, and spreads the single bit across a whole byte.

Input words are accepted on a valid strobe. The result appears in a register one clock later, together with an output valid strobe. The register keeps its contents while no new input arrives. Channel and field widths are parameters, and the default configuration is 8-bit channels with 5-bit fields. Bit positions below use LSB-0 numbering for that default.

Top module: `pixel_fmt_conv`

## Requirements
- R1: A synchronous active-high reset clears `out_word` to 0 and `out_valid` to 0 from the next rising edge on.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` = 1, and 0 otherwise.
- R3: In pack mode (`in_unpack` = 0), the result holds `in_word[23:19]` at bits [14:10], `in_word[15:11]` at bits [9:5] and `in_word[7:3]` at bits [4:0].
- R4: In pack mode, result bit 15 equals `in_word[24]`, the least significant bit of the top byte.
- R5: In pack mode, result bits [31:16] are zero, and input bits 31:25, 18:16, 10:8 and 2:0 have no effect.
- R6: In unpack mode (`in_unpack` = 1), each 5-bit field f of `in_word` at [14:10], [9:5] and [4:0] becomes the byte {f, f[4:2]} at result bits [23:16], [15:8] and [7:0] respectively.
- R7: In unpack mode, result bits [31:24] are 0xFF when `in_word[15]` is 1, and 0x00 when it is 0.
- R8: In unpack mode, `in_word[31:16]` has no effect on the result.
- R9: While `in_valid` is 0, `out_word` keeps its previous value whatever `in_word` and `in_unpack` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_unpack | input | 1 | 0 = pack 32→16, 1 = unpack 16→32 |
| in_word | input | 32 | Input pixel word |
| out_valid | output | 1 | Result updated in this cycle |
| out_word | output | 32 | Converted pixel, zero-extended in pack mode |

## Verification
The bench builds the block with its default 8-bit channels and 5-bit fields. At that size, every 16-bit unpack input can be swept exhaustively, with arbitrary upper bits in each case. Pack inputs are covered by walking-one words and several thousand arithmetically scattered words. Together these exercise every field boundary, both values of the single-bit channel and the bits that must be ignored. Idle stretches with changing inputs, and a reset in the middle of the run, check the hold and clear behaviour.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    // Default channel geometry
    localparam int unsigned CH_W_DEF    = 8;  // bits per channel, wide format
    localparam int unsigned FIELD_W_DEF = 5;  // bits per colour field, narrow format
    localparam int unsigned N_COLOUR    = 3;  // colour channels (the fourth is the 1-bit one)
    localparam int unsigned N_CHAN      = N_COLOUR + 1;

    typedef enum logic {
        DIR_PACK   = 1'b0,
        DIR_UNPACK = 1'b1
    } conv_dir_e;

    // Default-sized views of one pixel in each format
    typedef struct packed {
        logic [CH_W_DEF-1:0] top;
        logic [CH_W_DEF-1:0] c2;
        logic [CH_W_DEF-1:0] c1;
        logic [CH_W_DEF-1:0] c0;
    } wide_px_t;

    typedef struct packed {
        logic                   top;
        logic [FIELD_W_DEF-1:0] c2;
        logic [FIELD_W_DEF-1:0] c1;
        logic [FIELD_W_DEF-1:0] c0;
    } narrow_px_t;

    // Register contents handed from the converter to the output stage
    typedef struct packed {
        logic                              vld;
        logic [N_CHAN*CH_W_DEF-1:0]        word;
    } stage_in_t;

endpackage

// File: rtl/pxc_pack.sv
module pxc_pack #(
    parameter int unsigned CH_W    = pxc_pkg::CH_W_DEF,
    parameter int unsigned FIELD_W = pxc_pkg::FIELD_W_DEF
) (
    input  logic [pxc_pkg::N_CHAN*CH_W-1:0] wide_i,
    output logic [pxc_pkg::N_CHAN*CH_W-1:0] word_o
);
    localparam int unsigned WIDE_W   = pxc_pkg::N_CHAN * CH_W;
    localparam int unsigned NARROW_W = pxc_pkg::N_COLOUR * FIELD_W + 1;
    localparam int unsigned DROP_W   = CH_W - FIELD_W;

    logic [NARROW_W-1:0] narrow;

    // Colour channels: keep the top FIELD_W bits of each byte
    for (genvar c = 0; c < int'(pxc_pkg::N_COLOUR); c++) begin : g_col
        assign narrow[c*FIELD_W +: FIELD_W] = wide_i[c*CH_W + DROP_W +: FIELD_W];
    end

    // Single-bit channel: lowest bit of the top channel
    assign narrow[NARROW_W-1] = wide_i[pxc_pkg::N_COLOUR*CH_W];

    // Zero-extend into the wide register
    assign word_o = {{(WIDE_W-NARROW_W){1'b0}}, narrow};

endmodule

// File: rtl/pxc_unpack.sv
module pxc_unpack #(
    parameter int unsigned CH_W    = pxc_pkg::CH_W_DEF,
    parameter int unsigned FIELD_W = pxc_pkg::FIELD_W_DEF
) (
    input  logic [pxc_pkg::N_CHAN*CH_W-1:0] word_i,
    output logic [pxc_pkg::N_CHAN*CH_W-1:0] wide_o
);
    localparam int unsigned NARROW_W = pxc_pkg::N_COLOUR * FIELD_W + 1;
    localparam int unsigned FILL_W   = CH_W - FIELD_W;  // must lie in 1..FIELD_W

    // Only the low NARROW_W bits of the word are meaningful here
    logic [NARROW_W-1:0] narrow;
    assign narrow = word_i[NARROW_W-1:0];

    // Colour channels: repeat the field's high bits into the vacated low bits
    for (genvar c = 0; c < int'(pxc_pkg::N_COLOUR); c++) begin : g_col
        logic [FIELD_W-1:0] fld;
        assign fld = narrow[c*FIELD_W +: FIELD_W];
        assign wide_o[c*CH_W +: CH_W] = {fld, fld[FIELD_W-1 -: FILL_W]};
    end

    // Single-bit channel fans out over the whole top channel
    assign wide_o[pxc_pkg::N_COLOUR*CH_W +: CH_W] = {CH_W{narrow[NARROW_W-1]}};

endmodule

// File: rtl/pxc_stage.sv
module pxc_stage #(
    parameter int unsigned WORD_W = pxc_pkg::N_CHAN * pxc_pkg::CH_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            word_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                word_o <= word_i;
            end
        end
    end

    // R9: register keeps its value on idle cycles
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(word_o));

    // R1: reset clears both outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!vld_o && word_o == '0));

endmodule

// File: rtl/pixel_fmt_conv.sv
module pixel_fmt_conv #(
    parameter int unsigned CH_W    = pxc_pkg::CH_W_DEF,
    parameter int unsigned FIELD_W = pxc_pkg::FIELD_W_DEF
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic                               in_unpack,
    input  logic [pxc_pkg::N_CHAN*CH_W-1:0]    in_word,
    output logic                               out_valid,
    output logic [pxc_pkg::N_CHAN*CH_W-1:0]    out_word
);
    import pxc_pkg::*;

    localparam int unsigned WORD_W   = N_CHAN * CH_W;
    localparam int unsigned NARROW_W = N_COLOUR * FIELD_W + 1;
    localparam int unsigned TOP_LSB  = N_COLOUR * CH_W;
    localparam int unsigned FILL_W   = CH_W - FIELD_W;

    conv_dir_e         dir;
    logic [WORD_W-1:0] packed_w;
    logic [WORD_W-1:0] unpacked_w;
    logic [WORD_W-1:0] result_w;

    assign dir = conv_dir_e'(in_unpack);

    pxc_pack #(.CH_W(CH_W), .FIELD_W(FIELD_W)) u_pack (
        .wide_i (in_word),
        .word_o (packed_w)
    );

    pxc_unpack #(.CH_W(CH_W), .FIELD_W(FIELD_W)) u_unpack (
        .word_i (in_word),
        .wide_o (unpacked_w)
    );

    always_comb begin
        unique case (dir)
            DIR_PACK:   result_w = packed_w;
            DIR_UNPACK: result_w = unpacked_w;
            default:    result_w = packed_w;
        endcase
    end

    pxc_stage #(.WORD_W(WORD_W)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .word_i (result_w),
        .vld_o  (out_valid),
        .word_o (out_word)
    );

    // R2: one-cycle valid latency
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: single-bit channel taken from the lowest bit of the top byte
    p_pack_top_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_unpack) |=> (out_word[NARROW_W-1] == $past(in_word[TOP_LSB])));

    // R5: upper half cleared after a pack
    p_pack_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_unpack) |=> (out_word[WORD_W-1:NARROW_W] == '0));

    // R6: low bits of each widened channel repeat its high bits
    p_unpack_repeat_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_unpack) |=>
            (out_word[CH_W +: FILL_W] == out_word[2*CH_W-1 -: FILL_W]));

    // R7: top byte is all zeros or all ones after an unpack
    p_unpack_top_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_unpack) |=>
            (out_word[TOP_LSB +: CH_W] == '0 || out_word[TOP_LSB +: CH_W] == '1));

endmodule

// File: tb/pixel_fmt_conv_bench.sv
module pixel_fmt_conv_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_unpack = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pixel_fmt_conv u_pixel_fmt_conv (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_unpack (in_unpack),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pack(input logic [31:0] x);
        int unsigned a, c2, c1, c0;
        a  = (x / 32'h0100_0000) % 2;
        c2 = (x / 32'h0001_0000) % 256 / 8;
        c1 = (x / 32'h0000_0100) % 256 / 8;
        c0 = x % 256 / 8;
        return 32'(a * 32768 + c2 * 1024 + c1 * 32 + c0);
    endfunction

    function automatic int unsigned widen5(input int unsigned f);
        return f * 8 + f / 4;
    endfunction

    // Drive one transfer at a falling edge, sample after the next rising edge
    task automatic xfer(input logic v, input logic dir, input logic [31:0] w);
        @(negedge clk);
        in_valid  = v;
        in_unpack = dir;
        in_word   = w;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset out_word", out_word, 32'h0);
        check("R1 reset out_valid", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R3/R4/R5: walking ones through the pack path
        for (int b = 0; b < 32; b++) begin
            xfer(1'b1, 1'b0, 32'h1 << b);
            check("R3 R4 R5 pack walking bit", out_word, exp_pack(32'h1 << b));
            check("R2 valid after input", {31'b0, out_valid}, 32'h1);
        end

        // R3/R4/R5: scattered pack words
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] x;
            x = 32'(i) * 32'h9E37_79B9 ^ (32'(i) << 13) ^ 32'h5A5A_0F0F;
            xfer(1'b1, 1'b0, x);
            check("R3 pack colour fields", {17'b0, out_word[14:0]}, {17'b0, exp_pack(x)[14:0]});
            check("R4 pack top bit", {31'b0, out_word[15]}, {31'b0, x[24]});
            check("R5 pack upper zero", {16'b0, out_word[31:16]}, 32'h0);
        end

        // R6/R7/R8: exhaustive unpack with junk in the upper half
        for (int i = 0; i < 65536; i++) begin
            logic [31:0] x;
            int unsigned exp_col;
            x = ((32'(i) * 32'h0001_9D3F) << 16) | 32'(i);
            xfer(1'b1, 1'b1, x);
            exp_col = widen5((i / 1024) % 32) * 65536 + widen5((i / 32) % 32) * 256
                    + widen5(i % 32);
            check("R6 unpack colour widen", {8'b0, out_word[23:0]}, 32'(exp_col));
            check("R7 unpack top byte", {24'b0, out_word[31:24]},
                  (i >= 32768) ? 32'hFF : 32'h0);
            if ((i % 4096) == 7) begin
                // R8: same low half, other upper half, same result
                held = out_word;
                xfer(1'b1, 1'b1, ~x & 32'hFFFF_0000 | 32'(i));
                check("R8 upper half ignored", out_word, held);
            end
        end

        // R2/R9: idle cycles with changing inputs
        xfer(1'b1, 1'b0, 32'hC3A5_F00F);
        held = out_word;
        check("R3 pack before idle", held, exp_pack(32'hC3A5_F00F));
        for (int k = 0; k < 20; k++) begin
            xfer(1'b0, k[0], 32'(k) * 32'h1357_9BDF);
            check("R9 hold while idle", out_word, held);
            check("R2 valid low while idle", {31'b0, out_valid}, 32'h0);
        end

        // R1: reset mid-run
        xfer(1'b1, 1'b1, 32'h0000_FFFF);
        check("R7 all-ones pixel", out_word, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset out_word", out_word, 32'h0);
        check("R1 mid-run reset out_valid", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule